// File: doc/BRIEF.md
# Serial Frame Deframer

This block sits after the bit recovery and destuffing stage of a serial receiver. It takes one recovered bit per qualified cycle (`bit_vld`/`bit_dat`) and turns the stream into frames. While idle it watches for a run of three consecutive one bits. An idle line carries only zeros, so such a run cannot appear there. After that marker it collects a 16-bit header, most significant bit first. The upper byte of the header is the packet type and the lower byte is the payload size, counted in 16-bit words.

The block then collects exactly that many 16-bit words and presents each one on a word output. A one-cycle valid strobe goes with each word. Start-of-frame and end-of-frame strobes mark the first and last words. The decoded header is presented once with its own strobe. If the upstream receiver reports a synchronisation error, the frame in progress is dropped, a one-cycle bad-frame pulse is raised, and the block goes back to hunting. Checking the frame contents, storing whole packets and interpreting types are left to later stages.

Top module: `frame_deframer`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, every output is zero.
- R2: The block leaves the hunting state only after three accepted one bits in a row. An accepted zero restarts the count. Cycles with `bit_vld` low have no effect, whatever `bit_dat` holds.
- R3: The 16 accepted bits that follow the marker form the header, MSB first. `hdr_type` = bits 15..8 and `hdr_len` = bits 7..0. `hdr_vld` pulses for one cycle, in the cycle after the 16th header bit is accepted.
- R4: After a header with nonzero length N, exactly N words of 16 bits each are assembled MSB first. Each word appears on `word_dat` with a one-cycle `word_vld`, in the cycle after its 16th bit is accepted.
- R5: `word_sof` is high together with `word_vld` for the first word of a frame only. `word_eof` is high together with `word_vld` for the last word only. A one-word frame raises both on that word.
- R6: A header with length 0 produces `hdr_vld` and no word output, and the block returns to hunting at once.
- R7: After the last word the block hunts again. No output strobe appears until a new marker and header have been received.
- R8: A `sync_err` pulse while a header or payload is being collected raises `frame_bad` for one cycle in the following cycle. It discards the partial frame, and no further word of that frame is produced. A `sync_err` while hunting gives no `frame_bad` and clears the run of ones seen so far.
- R9: A bit presented in the same cycle as `sync_err` is discarded, even when `bit_vld` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | Qualifies `bit_dat` this cycle |
| bit_dat | input | 1 | Recovered, destuffed data bit |
| sync_err | input | 1 | Synchronisation loss reported by the bit receiver |
| hdr_vld | output | 1 | One-cycle strobe: header fields valid |
| hdr_type | output | 8 | Packet type from the header |
| hdr_len | output | 8 | Payload length in 16-bit words |
| word_vld | output | 1 | One-cycle strobe: payload word valid |
| word_dat | output | 16 | Payload word |
| word_sof | output | 1 | First word of the frame |
| word_eof | output | 1 | Last word of the frame |
| frame_bad | output | 1 | One-cycle pulse: frame aborted |

## Verification
Every result is registered exactly once. The header strobe, each word strobe with its start and end marks, and the bad-frame pulse are all due in the cycle after the input cycle that causes them: the 16th bit of a header or word, or the error pulse. The bench drives one input cycle per step and samples all outputs 5 ns after the rising edge that takes in that cycle. Each check therefore lands on the one cycle in which its result is due. After every other bit the bench checks that all strobes are low, which catches strobes that come early, late or more than once.

// File: rtl/dfr_pkg.sv
package dfr_pkg;
  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_HEADER  = 2'd1,
    ST_PAYLOAD = 2'd2
  } dfr_state_e;
endpackage

// File: rtl/dfr_sync_hunter.sv
// Counts consecutive accepted ones; fires on the one that completes the marker.
module dfr_sync_hunter #(
  parameter int SYNC_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  input  logic bit_in,
  output logic sync_hit
);
  localparam int RUN_W = $clog2(SYNC_LEN + 1);

  logic [RUN_W-1:0] run_q;

  assign sync_hit = en && bit_in && (run_q == RUN_W'(SYNC_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (clr || sync_hit) begin
      run_q <= '0;
    end else if (en) begin
      run_q <= bit_in ? run_q + 1'b1 : '0;
    end
  end

  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_q < RUN_W'(SYNC_LEN)); // R2
endmodule

// File: rtl/dfr_shifter.sv
// MSB-first word assembler with a bit counter.
module dfr_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         clr,
  input  logic         bit_in,
  output logic [W-1:0] next_word,
  output logic         full
);
  localparam int CNT_W = $clog2(W);

  logic [W-1:0]     sh_q;
  logic [CNT_W-1:0] cnt_q;

  assign next_word = {sh_q[W-2:0], bit_in};
  assign full      = shift_en && (cnt_q == CNT_W'(W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (shift_en) begin
      sh_q  <= next_word;
      cnt_q <= full ? '0 : cnt_q + 1'b1;
    end
  end

  AST_CLR_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !full); // R8
endmodule

// File: rtl/dfr_word_counter.sv
// Remaining payload words of the current frame.
module dfr_word_counter #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);
  logic [LEN_W-1:0] rem_q;

  assign last = (rem_q == LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (load) begin
      rem_q <= load_val;
    end else if (dec) begin
      rem_q <= rem_q - 1'b1;
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (rem_q != '0)); // R4
endmodule

// File: rtl/frame_deframer.sv
module frame_deframer
  import dfr_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int TYPE_W   = 8,
  parameter int SYNC_LEN = 3,
  localparam int LEN_W   = WORD_W - TYPE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_vld,
  input  logic              bit_dat,
  input  logic              sync_err,
  output logic              hdr_vld,
  output logic [TYPE_W-1:0] hdr_type,
  output logic [LEN_W-1:0]  hdr_len,
  output logic              word_vld,
  output logic [WORD_W-1:0] word_dat,
  output logic              word_sof,
  output logic              word_eof,
  output logic              frame_bad
);
  function automatic logic [TYPE_W-1:0] type_of(input logic [WORD_W-1:0] h);
    return h[WORD_W-1 -: TYPE_W];
  endfunction

  function automatic logic [LEN_W-1:0] len_of(input logic [WORD_W-1:0] h);
    return h[LEN_W-1:0];
  endfunction

  dfr_state_e        state_q;
  logic              accept, hunt_en, shift_en, shift_clr;
  logic              sync_hit, full, last_word, first_q;
  logic              hdr_done, word_done, len_zero;
  logic [WORD_W-1:0] next_word;

  // Named internal events
  assign accept    = bit_vld && !sync_err;
  assign hunt_en   = accept && (state_q == ST_HUNT);
  assign shift_en  = accept && (state_q != ST_HUNT);
  assign shift_clr = sync_err || (state_q == ST_HUNT);
  assign hdr_done  = full && (state_q == ST_HEADER);
  assign word_done = full && (state_q == ST_PAYLOAD);
  assign len_zero  = (len_of(next_word) == '0);

  dfr_sync_hunter #(.SYNC_LEN(SYNC_LEN)) i_hunter (
    .clk(clk), .rst_n(rst_n), .en(hunt_en), .clr(sync_err),
    .bit_in(bit_dat), .sync_hit(sync_hit)
  );

  dfr_shifter #(.W(WORD_W)) i_shifter (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .clr(shift_clr),
    .bit_in(bit_dat), .next_word(next_word), .full(full)
  );

  dfr_word_counter #(.LEN_W(LEN_W)) i_counter (
    .clk(clk), .rst_n(rst_n), .load(hdr_done), .load_val(len_of(next_word)),
    .dec(word_done), .last(last_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
    end else if (sync_err) begin
      state_q <= ST_HUNT;
    end else begin
      unique case (state_q)
        ST_HUNT:    if (sync_hit)  state_q <= ST_HEADER;
        ST_HEADER:  if (hdr_done)  state_q <= len_zero ? ST_HUNT : ST_PAYLOAD;
        ST_PAYLOAD: if (word_done && last_word) state_q <= ST_HUNT;
        default:    state_q <= ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_q   <= 1'b0;
      hdr_vld   <= 1'b0;
      hdr_type  <= '0;
      hdr_len   <= '0;
      word_vld  <= 1'b0;
      word_dat  <= '0;
      word_sof  <= 1'b0;
      word_eof  <= 1'b0;
      frame_bad <= 1'b0;
    end else begin
      hdr_vld   <= hdr_done;
      word_vld  <= word_done;
      word_sof  <= word_done && first_q;
      word_eof  <= word_done && last_word;
      frame_bad <= sync_err && (state_q != ST_HUNT);
      if (hdr_done) begin
        hdr_type <= type_of(next_word);
        hdr_len  <= len_of(next_word);
        first_q  <= 1'b1;
      end else if (word_done) begin
        first_q  <= 1'b0;
      end
      if (word_done) word_dat <= next_word;
    end
  end

  AST_MARKS_NEED_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (word_sof || word_eof) |-> word_vld); // R5
  AST_WORD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |=> !word_vld); // R4
  AST_HDR_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(hdr_vld && word_vld)); // R3
  AST_ERR_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |=> (!word_vld && !hdr_vld)); // R8
  AST_BAD_NEEDS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    frame_bad |-> $past(sync_err)); // R8
  AST_LEN0_HUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_done && len_zero && !sync_err) |=> (state_q == ST_HUNT)); // R6
endmodule

// File: tb/test_frame_deframer.sv
module test_frame_deframer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_vld = 1'b0, bit_dat = 1'b0, sync_err = 1'b0;
  logic        hdr_vld, word_vld, word_sof, word_eof, frame_bad;
  logic [7:0]  hdr_type, hdr_len;
  logic [15:0] word_dat;

  int vectors = 0;
  int miscompares = 0;

  always #10 clk = ~clk;

  frame_deframer i_frame_deframer (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_dat(bit_dat),
    .sync_err(sync_err), .hdr_vld(hdr_vld), .hdr_type(hdr_type),
    .hdr_len(hdr_len), .word_vld(word_vld), .word_dat(word_dat),
    .word_sof(word_sof), .word_eof(word_eof), .frame_bad(frame_bad)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // One input cycle; outputs sampled 5 ns after the edge that takes it in.
  task automatic step(input logic v, input logic d, input logic e);
    @(negedge clk);
    bit_vld = v; bit_dat = d; sync_err = e;
    @(posedge clk);
    #5;
  endtask

  task automatic quiet(input string req);
    chk(!word_vld && !hdr_vld && !frame_bad && !word_sof && !word_eof, req,
        {word_vld, hdr_vld, frame_bad, word_sof, word_eof}, 0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      step(1'b0, i[0], 1'b0);
      quiet("R2 idle cycle");
    end
  endtask

  task automatic send_bit(input logic b, input int gap);
    idle(gap);
    step(1'b1, b, 1'b0);
  endtask

  function automatic logic [15:0] wfun(input int seed, input int idx);
    return 16'((seed * 7919 + idx * 40503 + (idx << 11)) ^ (seed << 5));
  endfunction

  task automatic send_sync(input int gap);
    for (int i = 0; i < 3; i++) begin
      send_bit(1'b1, gap);
      quiet("R2 marker bit");
    end
  endtask

  task automatic send_frame(input logic [7:0] typ, input logic [7:0] len, input int seed, input int gap);
    logic [15:0] h;
    logic [15:0] w;
    h = {typ, len};
    send_sync(gap);
    for (int i = 15; i >= 0; i--) begin
      send_bit(h[i], gap);
      if (i != 0) quiet("R3 header bit");
    end
    chk(hdr_vld && !word_vld, "R3 hdr_vld", hdr_vld, 1);
    chk(hdr_type == typ, "R3 hdr_type", hdr_type, typ);
    chk(hdr_len == len, "R3 hdr_len", hdr_len, len);
    for (int k = 0; k < int'(len); k++) begin
      w = wfun(seed, k);
      for (int i = 15; i >= 0; i--) begin
        send_bit(w[i], gap);
        if (i != 0) quiet("R4 payload bit");
      end
      chk(word_vld, "R4 word_vld", word_vld, 1);
      chk(word_dat == w, "R4 word_dat", word_dat, w);
      chk(word_sof == (k == 0), "R5 word_sof", word_sof, k == 0);
      chk(word_eof == (k == int'(len) - 1), "R5 word_eof", word_eof, k == int'(len) - 1);
    end
    // R6/R7: nothing more after the frame; zeros cannot resync
    for (int i = 0; i < 20; i++) begin
      step(1'b1, 1'b0, 1'b0);
      quiet("R7 after frame");
    end
  endtask

  initial begin
    #4_000_000;
    miscompares++;
    $display("FAIL watchdog: actual 0 expected 1 (run completed)");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    // R1: reset state, with activity on the inputs
    bit_vld = 1'b1; bit_dat = 1'b1;
    repeat (4) @(posedge clk);
    #5;
    chk({hdr_vld, word_vld, word_sof, word_eof, frame_bad} == 0, "R1 strobes in reset",
        {hdr_vld, word_vld, word_sof, word_eof, frame_bad}, 0);
    chk({hdr_type, hdr_len, word_dat} == 0, "R1 data in reset", {hdr_type, hdr_len, word_dat}, 0);
    @(negedge clk);
    rst_n = 1'b1; bit_vld = 1'b0; bit_dat = 1'b0;
    @(posedge clk); #5;
    chk({hdr_vld, word_vld, frame_bad, hdr_type, hdr_len, word_dat} == 0, "R1 after release",
        {hdr_vld, word_vld, frame_bad}, 0);

    // R3..R7 sweep: lengths 0..6, several types, bit gaps 0..2
    for (int g = 0; g < 3; g++)
      for (int len = 0; len < 7; len++)
        send_frame(8'(8'h81 + len * 37 + g), 8'(len), len * 3 + g, g);

    // R4 maximum length
    send_frame(8'hFF, 8'd255, 99, 0);

    // R2: interrupted runs of ones must not sync early
    send_bit(1'b1, 0); quiet("R2 partial run");
    send_bit(1'b1, 0); quiet("R2 partial run");
    send_bit(1'b0, 0); quiet("R2 zero restart");
    send_bit(1'b1, 0); quiet("R2 partial run");
    send_bit(1'b1, 0); quiet("R2 partial run");
    send_bit(1'b0, 0); quiet("R2 zero restart");
    send_frame(8'hA5, 8'd2, 7, 0);

    // R8: error while hunting clears run, no frame_bad
    send_bit(1'b1, 0); send_bit(1'b1, 0);
    step(1'b0, 1'b0, 1'b1);
    chk(!frame_bad, "R8 err in hunt", frame_bad, 0);
    send_bit(1'b1, 0); quiet("R8 run cleared");
    for (int i = 0; i < 18; i++) begin step(1'b1, 1'b0, 1'b0); quiet("R8 no false sync"); end

    // R9: bit with sync_err is discarded
    send_bit(1'b1, 0); send_bit(1'b1, 0);
    step(1'b1, 1'b1, 1'b1);
    chk(!frame_bad, "R9 err bit in hunt", frame_bad, 0);
    for (int i = 0; i < 18; i++) begin step(1'b1, 1'b0, 1'b0); quiet("R9 bit dropped"); end

    // R8: abort in header
    send_sync(0);
    for (int i = 0; i < 5; i++) begin send_bit(1'b1, 0); quiet("R8 header part"); end
    step(1'b0, 1'b0, 1'b1);
    chk(frame_bad, "R8 frame_bad header", frame_bad, 1);
    step(1'b0, 1'b0, 1'b0);
    chk(!frame_bad, "R8 bad is one cycle", frame_bad, 0);
    send_frame(8'h3C, 8'd1, 11, 1);

    // R8/R9: abort in payload with a valid bit in the error cycle
    send_sync(0);
    for (int i = 15; i >= 0; i--) send_bit(i == 2, 0); // type 0, len 4
    chk(hdr_vld && hdr_len == 8'd4, "R3 abort hdr", hdr_len, 4);
    for (int i = 15; i >= 0; i--) send_bit(wfun(5, 0) >> i, 0);
    chk(word_vld && word_sof && word_dat == wfun(5, 0), "R5 abort first word", word_dat, wfun(5, 0));
    for (int i = 0; i < 6; i++) begin send_bit(1'b0, 0); quiet("R8 payload part"); end
    step(1'b1, 1'b1, 1'b1);
    chk(frame_bad && !word_vld, "R8 frame_bad payload", frame_bad, 1);
    for (int i = 0; i < 60; i++) begin step(1'b1, 1'b0, 1'b0); quiet("R8 frame dropped"); end
    send_frame(8'h5A, 8'd3, 21, 0);

    step(1'b0, 1'b0, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule